// File: doc/BRIEF.md
# Patch and Data-Value Break Response Unit

This block sits behind an address matcher on an on-chip bus. For every access that completes, the matcher supplies one match pulse per channel. Channels come in pairs, and each pair owns a small control word and two data registers. Each channel has an interrupt-enable bit and a patch-enable bit, and together they choose one of four responses:

- **Polling only:** the match is recorded in a sticky flag and nothing else happens.
- **Patch:** a matched read returns register contents in place of memory, and a matched write is dropped.
- **Operand break:** the flag is set and a break request follows the access.
- **Data-value break:** on the even channel of a pair, the transferred data is compared against the even register, with the odd register acting as a don't-care mask.

The substituted read data and the write-drop signal are combinational for the access cycle. Flags update at the end of that cycle. The break request is formed from the registered flags, so it appears in the cycle after the access. A global break-enable input gates the request. Software programs the registers and polls the flags through a simple register port.

Top module: `patch_break_unit`

## Requirements
- R1: After synchronous active-low reset, every control word and data register reads 0, `brk_req` and `wr_block` are 0, and `rd_data` equals `mem_rdata`.
- R2: A channel with both enables 0 sets its sticky flag on a matched access. It leaves `rd_data`, `wr_block` and `brk_req` untouched.
- R3: A channel with patch enable only, on a matched word read, drives `rd_data` with its own data register (even channel: even register; odd channel: odd register) and sets its flag.
- R4: On a matched byte read in patch mode, only the addressed lane is substituted. `acc_hi`=1 replaces bits 15:8 and `acc_hi`=0 replaces bits 7:0; the other lane carries `mem_rdata`.
- R5: A matched write in patch mode asserts `wr_block` in the access cycle, and `rd_data` stays equal to `mem_rdata`. `wr_block` is never 1 outside a valid write.
- R6: A channel with interrupt enable only sets its flag on a match and changes no data. `brk_req` is 0 during the access and 1 from the next cycle.
- R7: An even channel with both enables sets its flag only if the observed data equals the even register on every bit where the odd register holds 0. The observed data is `acc_wdata` on writes and `mem_rdata` on reads. On byte transfers only the addressed lane is compared. No data is changed.
- R8: An odd channel with both enables set does nothing on a match.
- R9: The control word has odd patch enable at bit 5, even patch enable at bit 4, odd interrupt enable at bit 3, even interrupt enable at bit 2, odd flag at bit 1 and even flag at bit 0. Enables read back as written. Selector value 3 reads 0.
- R10: Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. A flag set in the same cycle as a clearing write ends up set.
- R11: `brk_req` equals `brk_en` AND the OR over all channels of (flag AND interrupt enable).
- R12: When several patch channels match one read, the lowest-numbered channel supplies the data. Match pulses without `acc_valid` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| brk_en | input | 1 | Global break enable |
| cfg_we | input | 1 | Register write strobe |
| cfg_pair | input | PAIR_IDX_W | Pair index for register access |
| cfg_sel | input | 2 | 0 control word, 1 even data, 2 odd data, 3 none |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data (combinational) |
| acc_valid | input | 1 | A bus access completes this cycle |
| acc_write | input | 1 | 1 write, 0 read |
| acc_byte | input | 1 | 1 byte transfer, 0 word transfer |
| acc_hi | input | 1 | Byte lane: 1 upper (odd address), 0 lower |
| acc_wdata | input | DATA_W | Write data on the bus |
| mem_rdata | input | DATA_W | Data returned by memory |
| match | input | 2*NUM_PAIRS | Per-channel address match pulses |
| rd_data | output | DATA_W | Read data after substitution |
| wr_block | output | 1 | Drop the current write |
| brk_req | output | 1 | Break request |

## Verification
The bench sweeps every channel through all four enable combinations, crossed with read/write, byte/word and both lanes. It predicts substitution, write drop, flag and break from the requirement arithmetic. A lane swap in byte patching, a wrong register choice for the odd channel, or an odd channel acting as a value comparator would each show up as a wrong `rd_data` or a wrong flag bit.

The data-value mask is tested at its edges: 0x1200 and 0x12FF hit, while 0x1300 misses. Reads and writes are deliberately given different data, so comparing the wrong bus flips the result. Directed cases cover the following:
- a clearing write racing a new match, where a clear-wins design would lose the flag;
- break gating by `brk_en` and by the interrupt enable;
- channel priority on a double match;
- match pulses arriving without a valid access.

// File: rtl/pbu_pkg.sv
// Shared definitions for the patch and break response unit.
// Assumes a 16-bit-style bus split into two byte lanes.
package pbu_pkg;

    // Response selected by {interrupt enable, patch enable}
    typedef enum logic [1:0] {
        ACT_POLL  = 2'b00,
        ACT_PATCH = 2'b01,
        ACT_OPBRK = 2'b10,
        ACT_DVBRK = 2'b11
    } act_e;

    // Register selector on the configuration port
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_DEVN = 2'd1,
        SEL_DODD = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    // Control word bit positions (software visible)
    localparam int PE_ODD_BIT  = 5;
    localparam int PE_EVEN_BIT = 4;
    localparam int IE_ODD_BIT  = 3;
    localparam int IE_EVEN_BIT = 2;
    localparam int FL_ODD_BIT  = 1;
    localparam int FL_EVEN_BIT = 0;
    localparam int CTRL_W      = 6;

endpackage

// File: rtl/pbu_pair_regs.sv
// Register file of one channel pair: enables, sticky flags, two data words.
// Assumes DATA_W >= 6. A flag set from a match wins over a clearing write.
module pbu_pair_regs #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_even,
    input  logic              wr_odd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        set_flag,
    output logic [1:0]        pe,
    output logic [1:0]        ie,
    output logic [1:0]        flag,
    output logic [DATA_W-1:0] d_even,
    output logic [DATA_W-1:0] d_odd
);
    import pbu_pkg::*;

    logic [1:0] keep;

    // Which flag bits survive this cycle's control write
    always_comb begin
        keep = wr_ctrl ? {wdata[FL_ODD_BIT], wdata[FL_EVEN_BIT]} : 2'b11;
    end

    // Enables, flags and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pe     <= '0;
            ie     <= '0;
            flag   <= '0;
            d_even <= '0;
            d_odd  <= '0;
        end else begin
            if (wr_ctrl) begin
                pe <= {wdata[PE_ODD_BIT], wdata[PE_EVEN_BIT]};
                ie <= {wdata[IE_ODD_BIT], wdata[IE_EVEN_BIT]};
            end
            flag <= set_flag | (flag & keep);
            if (wr_even) d_even <= wdata;
            if (wr_odd)  d_odd  <= wdata;
        end
    end

endmodule

// File: rtl/pbu_value_cmp.sv
// Masked data compare for a pair's even channel.
// Mask bit 1 = don't care. On byte transfers the unaddressed lane is ignored.
module pbu_value_cmp #(
    parameter int DATA_W = 16
) (
    input  logic              acc_write,
    input  logic              acc_byte,
    input  logic              acc_hi,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] cmp_val,
    input  logic [DATA_W-1:0] cmp_mask,
    output logic              hit
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] obs;
    logic [DATA_W-1:0] lane_ign;

    // Pick the data seen on the bus and the lane to ignore
    always_comb begin
        obs = acc_write ? acc_wdata : mem_rdata;
        if (!acc_byte)   lane_ign = '0;
        else if (acc_hi) lane_ign = {{HALF{1'b0}}, {HALF{1'b1}}};
        else             lane_ign = {{HALF{1'b1}}, {HALF{1'b0}}};
    end

    // Every cared-for bit must agree
    always_comb begin
        hit = ((obs ^ cmp_val) & ~cmp_mask & ~lane_ign) == '0;
    end

endmodule

// File: rtl/pbu_chan_decide.sv
// Per-channel response decision for one access cycle.
// IS_EVEN selects whether the data-value mode is available to this channel.
module pbu_chan_decide #(
    parameter bit IS_EVEN = 1'b1
) (
    input  logic acc_valid,
    input  logic acc_write,
    input  logic match,
    input  logic pe,
    input  logic ie,
    input  logic cmp_hit,
    output logic set_flag,
    output logic patch_rd,
    output logic patch_wr
);
    import pbu_pkg::*;

    logic hit;
    logic dv_ok;
    act_e act;

    // Decode the mode and qualify the match
    always_comb begin
        hit   = acc_valid & match;
        act   = act_e'({ie, pe});
        dv_ok = IS_EVEN ? cmp_hit : 1'b0;
    end

    // Action chosen by the mode
    always_comb begin
        set_flag = 1'b0;
        patch_rd = 1'b0;
        patch_wr = 1'b0;
        unique case (act)
            ACT_POLL:  set_flag = hit;
            ACT_PATCH: begin
                set_flag = hit;
                patch_rd = hit & ~acc_write;
                patch_wr = hit & acc_write;
            end
            ACT_OPBRK: set_flag = hit;
            ACT_DVBRK: set_flag = hit & dv_ok;
        endcase
    end

endmodule

// File: rtl/pbu_read_mux.sv
// Read data substitution. Lowest-numbered patching channel wins.
// Byte substitution replaces only the addressed lane.
module pbu_read_mux #(
    parameter int NCH    = 4,
    parameter int DATA_W = 16
) (
    input  logic                        acc_byte,
    input  logic                        acc_hi,
    input  logic [DATA_W-1:0]           mem_rdata,
    input  logic [NCH-1:0]              patch_rd,
    input  logic [NCH-1:0][DATA_W-1:0]  patch_data,
    output logic [DATA_W-1:0]           rd_data
);
    localparam int HALF = DATA_W / 2;
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [CH_W-1:0]   pick;
    logic              any;
    logic [DATA_W-1:0] src;

    // Priority pick, scanning down so the lowest index is kept
    always_comb begin
        pick = '0;
        any  = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (patch_rd[i]) begin
                pick = CH_W'(i);
                any  = 1'b1;
            end
        end
        src = patch_data[pick];
    end

    // Merge substituted lanes with memory data
    always_comb begin
        if (!any)          rd_data = mem_rdata;
        else if (!acc_byte) rd_data = src;
        else if (acc_hi)   rd_data = {src[DATA_W-1:HALF], mem_rdata[HALF-1:0]};
        else               rd_data = {mem_rdata[DATA_W-1:HALF], src[HALF-1:0]};
    end

endmodule

// File: rtl/patch_break_unit.sv
// Top of the patch and break response unit.
// Assumes match pulses are aligned with acc_valid for the completing access.
// Substitution and write drop are combinational; the break request is registered.
module patch_break_unit #(
    parameter int NUM_PAIRS  = 2,
    parameter int DATA_W     = 16,
    parameter int NCH        = 2 * NUM_PAIRS,
    parameter int PAIR_IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  brk_en,
    input  logic                  cfg_we,
    input  logic [PAIR_IDX_W-1:0] cfg_pair,
    input  logic [1:0]            cfg_sel,
    input  logic [DATA_W-1:0]     cfg_wdata,
    output logic [DATA_W-1:0]     cfg_rdata,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic                  acc_byte,
    input  logic                  acc_hi,
    input  logic [DATA_W-1:0]     acc_wdata,
    input  logic [DATA_W-1:0]     mem_rdata,
    input  logic [NCH-1:0]        match,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  wr_block,
    output logic                  brk_req
);
    import pbu_pkg::*;

    logic [NUM_PAIRS-1:0][1:0]        pe_a, ie_a, fl_a;
    logic [NUM_PAIRS-1:0][DATA_W-1:0] de_a, do_a;
    logic [NCH-1:0]                   set_flag, patch_rd, patch_wr;
    logic [NCH-1:0][DATA_W-1:0]       chan_data;
    logic [NCH-1:0]                   ie_flat, fl_flat;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        logic sel_me;
        logic cmp_hit;

        // Register port address decode for this pair
        always_comb begin
            sel_me = cfg_we && (cfg_pair == PAIR_IDX_W'(p));
        end

        pbu_pair_regs #(.DATA_W(DATA_W)) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_ctrl  (sel_me && (cfg_sel == SEL_CTRL)),
            .wr_even  (sel_me && (cfg_sel == SEL_DEVN)),
            .wr_odd   (sel_me && (cfg_sel == SEL_DODD)),
            .wdata    (cfg_wdata),
            .set_flag (set_flag[2*p+1 -: 2]),
            .pe       (pe_a[p]),
            .ie       (ie_a[p]),
            .flag     (fl_a[p]),
            .d_even   (de_a[p]),
            .d_odd    (do_a[p])
        );

        pbu_value_cmp #(.DATA_W(DATA_W)) u_cmp (
            .acc_write (acc_write),
            .acc_byte  (acc_byte),
            .acc_hi    (acc_hi),
            .acc_wdata (acc_wdata),
            .mem_rdata (mem_rdata),
            .cmp_val   (de_a[p]),
            .cmp_mask  (do_a[p]),
            .hit       (cmp_hit)
        );

        pbu_chan_decide #(.IS_EVEN(1'b1)) u_even (
            .acc_valid (acc_valid),
            .acc_write (acc_write),
            .match     (match[2*p]),
            .pe        (pe_a[p][0]),
            .ie        (ie_a[p][0]),
            .cmp_hit   (cmp_hit),
            .set_flag  (set_flag[2*p]),
            .patch_rd  (patch_rd[2*p]),
            .patch_wr  (patch_wr[2*p])
        );

        pbu_chan_decide #(.IS_EVEN(1'b0)) u_odd (
            .acc_valid (acc_valid),
            .acc_write (acc_write),
            .match     (match[2*p+1]),
            .pe        (pe_a[p][1]),
            .ie        (ie_a[p][1]),
            .cmp_hit   (1'b0),
            .set_flag  (set_flag[2*p+1]),
            .patch_rd  (patch_rd[2*p+1]),
            .patch_wr  (patch_wr[2*p+1])
        );

        // Flatten per-channel views
        always_comb begin
            chan_data[2*p]   = de_a[p];
            chan_data[2*p+1] = do_a[p];
            ie_flat[2*p+1 -: 2] = ie_a[p];
            fl_flat[2*p+1 -: 2] = fl_a[p];
        end
    end

    pbu_read_mux #(.NCH(NCH), .DATA_W(DATA_W)) u_rmux (
        .acc_byte   (acc_byte),
        .acc_hi     (acc_hi),
        .mem_rdata  (mem_rdata),
        .patch_rd   (patch_rd),
        .patch_data (chan_data),
        .rd_data    (rd_data)
    );

    // Write drop and gated break request
    always_comb begin
        wr_block = |patch_wr;
        brk_req  = brk_en & (|(fl_flat & ie_flat));
    end

    // Register port read mux
    always_comb begin
        cfg_rdata = '0;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (cfg_pair == PAIR_IDX_W'(p)) begin
                unique case (sel_e'(cfg_sel))
                    SEL_CTRL: cfg_rdata = DATA_W'({pe_a[p][1], pe_a[p][0],
                                                   ie_a[p][1], ie_a[p][0],
                                                   fl_a[p][1], fl_a[p][0]});
                    SEL_DEVN: cfg_rdata = de_a[p];
                    SEL_DODD: cfg_rdata = do_a[p];
                    SEL_NONE: cfg_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/patch_break_unit_chk.sv
// Port-level temporal checks for the patch and break response unit.
module patch_break_unit_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              brk_en,
    input logic              cfg_we,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_block,
    input logic              brk_req
);

    // R1: the cycle after reset has no break request
    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !brk_req);

    // R5: writes are dropped only during a valid write
    p_wrblk_write_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_block |-> (acc_valid && acc_write));

    // R5: a write never alters the read data path
    p_write_no_subst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_write |-> (rd_data == mem_rdata));

    // R11: break request is gated by the global enable
    p_brk_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !brk_en |-> !brk_req);

    // R6: a new break follows an access or a register write
    p_brk_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(brk_req) && $stable(brk_en)) |-> ($past(acc_valid) || $past(cfg_we)));

    // R12: with no valid access, the read data is memory data
    p_idle_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (rd_data == mem_rdata));

endmodule

bind patch_break_unit patch_break_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .brk_en    (brk_en),
    .cfg_we    (cfg_we),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .mem_rdata (mem_rdata),
    .rd_data   (rd_data),
    .wr_block  (wr_block),
    .brk_req   (brk_req)
);

// File: tb/patch_break_unit_test.sv
module patch_break_unit_test;
    localparam int CLK_P = 10;
    localparam int NP    = 2;
    localparam int DW    = 16;
    localparam int NC    = 2 * NP;
    localparam logic [15:0] CMPV = 16'h1200;
    localparam logic [15:0] MSKV = 16'h00FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic brk_en = 1'b0;
    logic cfg_we = 1'b0;
    logic [0:0] cfg_pair = '0;
    logic [1:0] cfg_sel = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [DW-1:0] cfg_rdata;
    logic acc_valid = 1'b0, acc_write = 1'b0, acc_byte = 1'b0, acc_hi = 1'b0;
    logic [DW-1:0] acc_wdata = '0, mem_rdata = '0;
    logic [NC-1:0] match = '0;
    logic [DW-1:0] rd_data;
    logic wr_block, brk_req;

    int checks = 0;
    int fails  = 0;
    logic [15:0] got_rd;
    logic got_wb, got_brk;

    patch_break_unit #(.NUM_PAIRS(NP), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .brk_en(brk_en), .cfg_we(cfg_we),
        .cfg_pair(cfg_pair), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_byte(acc_byte), .acc_hi(acc_hi), .acc_wdata(acc_wdata),
        .mem_rdata(mem_rdata), .match(match), .rd_data(rd_data),
        .wr_block(wr_block), .brk_req(brk_req)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic cfg_write(input int p, input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_pair = 1'(p); cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input int p, input logic [1:0] s, output logic [15:0] v);
        cfg_pair = 1'(p); cfg_sel = s;
        #1 v = cfg_rdata;
    endtask

    task automatic do_access(input logic [NC-1:0] m, input bit wr, input bit by,
                             input bit hi, input logic [15:0] wd, input logic [15:0] md);
        @(negedge clk);
        acc_valid = 1'b1; match = m; acc_write = wr; acc_byte = by; acc_hi = hi;
        acc_wdata = wd; mem_rdata = md;
        #2;
        got_rd = rd_data; got_wb = wr_block; got_brk = brk_req;
        @(negedge clk);
        acc_valid = 1'b0; match = '0;
    endtask

    function automatic bit dv_hit(input logic [15:0] obs, input bit by, input bit hi);
        logic [15:0] ign;
        ign = !by ? 16'h0000 : (hi ? 16'h00FF : 16'hFF00);
        return ((obs ^ CMPV) & ~MSKV & ~ign) == 16'h0000;
    endfunction

    initial begin
        #(CLK_P * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int p = 0; p < NP; p++) begin
            for (int s = 0; s < 3; s++) begin
                cfg_read(p, 2'(s), v);
                chk("R1 reg reset", v, 0);
            end
        end
        mem_rdata = 16'h5A5A;
        acc_valid = 1'b1; #1;
        chk("R1 rd pass", rd_data, 16'h5A5A);
        chk("R1 wr_block", wr_block, 0);
        chk("R1 brk_req", brk_req, 0);
        acc_valid = 1'b0;

        // Data registers for the sweep
        brk_en = 1'b1;
        for (int p = 0; p < NP; p++) begin
            cfg_write(p, 2'd1, CMPV);
            cfg_write(p, 2'd2, MSKV);
        end

        // R9: control layout readback
        cfg_write(0, 2'd0, 16'h003C);
        cfg_read(0, 2'd0, v);
        chk("R9 enables readback", v, 16'h003C);
        cfg_read(0, 2'd3, v);
        chk("R9 sel3 reads zero", v, 0);
        cfg_write(0, 2'd0, 16'h0000);

        // Sweep: every channel x mode x direction x size x lane
        for (int ch = 0; ch < NC; ch++) begin
            for (int md = 0; md < 4; md++) begin
                for (int k = 0; k < 8; k++) begin
                    bit wr, by, hi, pe, ie, odd, pat, eflag;
                    int p;
                    logic [15:0] wd, mm, pd, erd, ctl;
                    wr = k[2]; by = k[1]; hi = k[0];
                    pe = md[0]; ie = md[1]; odd = ch[0]; p = ch / 2;
                    wd = 16'h127E; mm = 16'h3C5A;
                    ctl = 16'h0;
                    ctl[4 + int'(odd)] = pe;
                    ctl[2 + int'(odd)] = ie;
                    cfg_write(p, 2'd0, ctl);
                    do_access(NC'(1) << ch, wr, by, hi, wd, mm);
                    pat = pe & ~ie;
                    pd = odd ? MSKV : CMPV;
                    if (pat && !wr)
                        erd = !by ? pd : (hi ? {pd[15:8], mm[7:0]} : {mm[15:8], pd[7:0]});
                    else
                        erd = mm;
                    if (pe && ie) eflag = !odd && dv_hit(wr ? wd : mm, by, hi);
                    else          eflag = 1'b1;
                    chk(pat ? (by ? "R4 byte lane rd" : "R3 patch rd") : "R7 data unchanged",
                        got_rd, erd);
                    chk(pat ? "R5 write drop" : "R2 no write drop", got_wb, pat & wr);
                    chk("R6 no brk during access", got_brk, 0);
                    cfg_read(p, 2'd0, v);
                    chk((pe && ie) ? (odd ? "R8 odd both enables" : "R7 value match") : "R2 flag set",
                        v[int'(odd)], eflag);
                    chk("R6 brk after access", brk_req, eflag & ie);
                    cfg_write(p, 2'd0, 16'h0000);
                end
            end
        end

        // R7: mask boundaries, word writes on channel 0
        for (int i = 0; i < 4; i++) begin
            logic [15:0] d;
            bit e;
            d = (i == 0) ? 16'h1200 : (i == 1) ? 16'h12FF : (i == 2) ? 16'h1300 : 16'h0200;
            e = (i < 2);
            cfg_write(0, 2'd0, 16'h0014);
            do_access(4'b0001, 1'b1, 1'b0, 1'b0, d, 16'h1234);
            cfg_read(0, 2'd0, v);
            chk("R7 mask boundary", v[0], e);
        end
        // R7: read compares memory data, not write data
        cfg_write(0, 2'd0, 16'h0014);
        do_access(4'b0001, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'h12AB);
        cfg_read(0, 2'd0, v);
        chk("R7 read uses mem data", v[0], 1);
        cfg_write(0, 2'd0, 16'h0000);

        // R10: write 1 keeps, write 0 clears
        do_access(4'b0001, 1'b0, 1'b0, 1'b0, 0, 0);
        cfg_write(0, 2'd0, 16'h0001);
        cfg_read(0, 2'd0, v);
        chk("R10 write one keeps flag", v[0], 1);
        cfg_write(0, 2'd0, 16'h0000);
        cfg_read(0, 2'd0, v);
        chk("R10 write zero clears flag", v[0], 0);
        // R10: set wins over same-cycle clear
        @(negedge clk);
        cfg_we = 1'b1; cfg_pair = 1'b0; cfg_sel = 2'd0; cfg_wdata = 16'h0000;
        acc_valid = 1'b1; match = 4'b0001; acc_write = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; acc_valid = 1'b0; match = '0;
        cfg_read(0, 2'd0, v);
        chk("R10 set beats clear", v[0], 1);

        // R11: gating by brk_en and interrupt enable
        cfg_write(0, 2'd0, 16'h0005);
        #1 chk("R11 flag with ie", brk_req, 1);
        brk_en = 1'b0; #1;
        chk("R11 brk_en low", brk_req, 0);
        brk_en = 1'b1;
        cfg_write(0, 2'd0, 16'h0001);
        #1 chk("R11 no ie no brk", brk_req, 0);
        cfg_write(0, 2'd0, 16'h0000);

        // R12: priority and unqualified matches
        cfg_write(1, 2'd1, 16'hBEEF);
        cfg_write(0, 2'd0, 16'h0020);
        cfg_write(1, 2'd0, 16'h0010);
        do_access(4'b0110, 1'b0, 1'b0, 1'b0, 0, 16'h7777);
        chk("R12 lowest channel wins", got_rd, MSKV);
        cfg_write(0, 2'd0, 16'h0000);
        cfg_write(1, 2'd0, 16'h0000);
        @(negedge clk);
        match = 4'b1111; acc_valid = 1'b0; mem_rdata = 16'h4321;
        #1 chk("R12 no valid rd pass", rd_data, 16'h4321);
        @(negedge clk);
        match = '0;
        cfg_read(0, 2'd0, v);
        chk("R12 no valid no flag p0", v, 0);
        cfg_read(1, 2'd0, v);
        chk("R12 no valid no flag p1", v, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule